// File: doc/BRIEF.md
# Half-Duplex Bidirectional Line Repeater

This block decides the direction of one open-drain data line that links a host side to a card side. Each side has a sampled input and two enables, one that pulls the wire low and one that drives it high. The enables feed pad drivers or a wire model. While idle, both sides are released and each wire rests high on its pull-up. The first side whose synchronized input drops low becomes master. After a set number of clock cycles the block pulls the other side (the slave) low, so the low level is copied across. When the master lets go, the slave pull-down is released and a short active pull-up pulse speeds up the slave's rising edge. The block then rearms.

While a transfer is in progress, the slave's own input is ignored. The low that the block drives onto the slave wire therefore cannot come back and claim the line. A line enable puts the card contacts in their inactive state: the card wire is held low and the host wire is released. The edge delay, the pulse length and the synchronizer depth are parameters counted in clock cycles. At elaboration the block checks that the delay and the pulse together fit into half a 1 µs line period at the stated clock rate.

Top module: `bidir_line_repeater`

## Requirements
- R1: After reset, with `line_en` high and both wires high, all four drive enables are 0.
- R2: When the card input falls first, the card side is master: `host_drv_lo` goes to 1 and `card_drv_lo` stays 0.
- R3: When the host input falls first, the host side is master: `card_drv_lo` goes to 1 and `host_drv_lo` stays 0.
- R4: When both inputs fall before the same rising edge, the host side wins and only `card_drv_lo` is driven.
- R5: While a master is established, lows on the slave input, including extra external lows, never change the direction and never cause a drive on the master side.
- R6: Take the first rising edge after the master input goes low as edge 1. The slave pull-down is 0 up to edge EDGE_DLY+2 and is 1 after edge EDGE_DLY+3. The two-stage synchronizer accounts for the extra edges.
- R7: Once the master input is seen high again, the slave pull-down drops and the slave pull-up enable is 1 for exactly PU_LEN cycles. No side ever has both its enables at 1.
- R8: If the master input returns high before the edge delay expires, no enable on the slave side is asserted.
- R9: After the pull-up pulse, a new master is accepted only once both synchronized inputs have been high. While either wire stays low, no drive is started.
- R10: While `line_en` is 0, `card_drv_lo` is 1 and both host enables and `card_drv_hi` are 0. Any session in progress is abandoned, and the block rearms after `line_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | 1 = contacts active; 0 = card wire held low, host wire released |
| host_in | input | 1 | Level sampled from the host-side wire |
| card_in | input | 1 | Level sampled from the card-side wire |
| host_drv_lo | output | 1 | Pull host wire low |
| host_drv_hi | output | 1 | Active pull-up pulse on host wire |
| card_drv_lo | output | 1 | Pull card wire low |
| card_drv_hi | output | 1 | Active pull-up pulse on card wire |

## Verification
Two functions can fall into the same cycle: both sides can present a falling edge together, and the slave's sampled low can coincide with the master being established. The bench provokes the first case by pulling both wires low at the same falling clock edge. The result is judged correct when only the card pull-down rises and the host side is never driven. For the second case, the bench pulses the slave wire low externally while the slave pull-down is active, and also holds it low across the end of the pull-up pulse. It then confirms that no drive reverses direction and that nothing starts until both wires are released.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
   typedef enum logic [2:0] {
      RP_REARM = 3'd0,
      RP_IDLE  = 3'd1,
      RP_HWAIT = 3'd2,
      RP_HDRV  = 3'd3,
      RP_HPULL = 3'd4,
      RP_CWAIT = 3'd5,
      RP_CDRV  = 3'd6,
      RP_CPULL = 3'd7
   } rp_state_t;

   function automatic int rp_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rptr_sync.sv
module rptr_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("rptr_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_in} & {STAGES{1'b1}};
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rptr_arbiter.sv
module rptr_arbiter
   import rptr_pkg::*;
#(
   parameter int EDGE_DLY = 8,
   parameter int PU_LEN   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_en,
   input  logic host_s,
   input  logic card_s,
   output logic host_drv_lo,
   output logic host_drv_hi,
   output logic card_drv_lo,
   output logic card_drv_hi
);
   localparam int CNT_W = $clog2(rp_max(EDGE_DLY, PU_LEN) + 1);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(EDGE_DLY - 1);
   localparam logic [CNT_W-1:0] PU_LAST  = CNT_W'(PU_LEN - 1);

   rp_state_t        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             host_master, master_lvl;

   assign host_master = (st_q == RP_HWAIT) || (st_q == RP_HDRV) || (st_q == RP_HPULL);
   assign master_lvl  = host_master ? host_s : card_s;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         RP_REARM: if (host_s && card_s) st_d = RP_IDLE;
         RP_IDLE: begin
            cnt_d = '0;
            if (!host_s)      st_d = RP_HWAIT;
            else if (!card_s) st_d = RP_CWAIT;
         end
         RP_HWAIT, RP_CWAIT: begin
            if (master_lvl)             st_d = RP_REARM;
            else if (cnt_q == DLY_LAST) st_d = (st_q == RP_HWAIT) ? RP_HDRV : RP_CDRV;
            else                        cnt_d = cnt_q + 1'b1;
         end
         RP_HDRV, RP_CDRV: begin
            cnt_d = '0;
            if (master_lvl) st_d = (st_q == RP_HDRV) ? RP_HPULL : RP_CPULL;
         end
         RP_HPULL, RP_CPULL: begin
            if (cnt_q == PU_LAST) st_d = RP_REARM;
            else                  cnt_d = cnt_q + 1'b1;
         end
         default: st_d = RP_REARM;
      endcase
      if (!line_en) begin
         st_d  = RP_REARM;
         cnt_d = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= RP_REARM;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   always_comb begin
      host_drv_lo = 1'b0;
      host_drv_hi = 1'b0;
      card_drv_lo = 1'b0;
      card_drv_hi = 1'b0;
      if (!line_en) begin
         card_drv_lo = 1'b1;
      end else begin
         card_drv_lo = (st_q == RP_HDRV);
         card_drv_hi = (st_q == RP_HPULL);
         host_drv_lo = (st_q == RP_CDRV);
         host_drv_hi = (st_q == RP_CPULL);
      end
   end

   // R7: a side never pulls up and down at once
   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_drv_lo && card_drv_hi) && !(host_drv_lo && host_drv_hi));

   // R5: a host-mastered session never turns into a card-mastered one
   a_r5_anti_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en && host_master) |=> !(st_q == RP_CWAIT || st_q == RP_CDRV || st_q == RP_CPULL));

   // R8: master release during the delay ends the session without slave drive
   a_r8_early_release: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en && st_q == RP_HWAIT && host_s) |=> (st_q == RP_REARM && !card_drv_lo));

   // R9: arming happens only after both synchronized lines were high
   a_r9_rearm_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RP_IDLE && $past(st_q) == RP_REARM) |-> $past(host_s && card_s));

   // R10: a low enable always returns the sequencer to the rearm state
   a_r10_disable_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en |=> (st_q == RP_REARM));
endmodule

// File: rtl/bidir_line_repeater.sv
module bidir_line_repeater
   import rptr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int EDGE_DLY    = 8,
   parameter int PU_LEN      = 6,
   parameter int CLK_MHZ     = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_en,
   input  logic host_in,
   input  logic card_in,
   output logic host_drv_lo,
   output logic host_drv_hi,
   output logic card_drv_lo,
   output logic card_drv_hi
);
   localparam int HALF_PERIOD_CYC = CLK_MHZ / 2;

   if (EDGE_DLY < 1 || PU_LEN < 1) begin : g_bad_timing
      $error("bidir_line_repeater: EDGE_DLY and PU_LEN must be at least 1");
   end
   if (EDGE_DLY + PU_LEN > HALF_PERIOD_CYC) begin : g_bad_budget
      $error("bidir_line_repeater: delay plus pull-up pulse exceed half of a 1 us period");
   end

   logic host_s, card_s;

   rptr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_host_sync (
      .clk(clk), .rst_n(rst_n), .d_in(host_in), .q_out(host_s));

   rptr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_card_sync (
      .clk(clk), .rst_n(rst_n), .d_in(card_in), .q_out(card_s));

   rptr_arbiter #(.EDGE_DLY(EDGE_DLY), .PU_LEN(PU_LEN)) i_arb (
      .clk(clk), .rst_n(rst_n), .line_en(line_en),
      .host_s(host_s), .card_s(card_s),
      .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi),
      .card_drv_lo(card_drv_lo), .card_drv_hi(card_drv_hi));
endmodule

// File: tb/test_bidir_line_repeater.sv
`timescale 1ns/1ps
module test_bidir_line_repeater;
   localparam int ED = 8;
   localparam int PU = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_en = 1'b1;
   logic host_ext = 1'b0, card_ext = 1'b0;
   logic host_in, card_in;
   logic host_drv_lo, host_drv_hi, card_drv_lo, card_drv_hi;
   int   checks = 0, errors = 0;
   string cur_req = "R1";
   bit   done = 1'b0;

   always #2 clk = ~clk;

   assign host_in = !(host_ext || host_drv_lo);
   assign card_in = !(card_ext || card_drv_lo);

   bidir_line_repeater #(.SYNC_STAGES(2), .EDGE_DLY(ED), .PU_LEN(PU), .CLK_MHZ(250)) i_bidir_line_repeater (
      .clk(clk), .rst_n(rst_n), .line_en(line_en),
      .host_in(host_in), .card_in(card_in),
      .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi),
      .card_drv_lo(card_drv_lo), .card_drv_hi(card_drv_hi));

   // behavioural reference: modes 0 rearm,1 idle,2 wait,3 hold low,4 pulse
   bit hq[$], cq[$];
   int mode = 0, who = 0, tick = 0;
   bit mh, mc;
   always @(posedge clk) begin
      if (!rst_n) begin
         hq = '{1, 1}; cq = '{1, 1};
         mode = 0; tick = 0; who = 0;
      end else begin
         mh = hq[0]; mc = cq[0];
         void'(hq.pop_front()); void'(cq.pop_front());
         hq.push_back(host_in); cq.push_back(card_in);
         if (!line_en) begin mode = 0; tick = 0; end
         else begin
            case (mode)
               0: if (mh && mc) mode = 1;
               1: begin
                  tick = 0;
                  if (!mh) begin mode = 2; who = 0; end
                  else if (!mc) begin mode = 2; who = 1; end
               end
               2: if ((who == 0) ? mh : mc) mode = 0;
                  else if (tick == ED - 1) mode = 3;
                  else tick++;
               3: begin tick = 0; if ((who == 0) ? mh : mc) mode = 4; end
               4: if (tick == PU - 1) mode = 0; else tick++;
               default: mode = 0;
            endcase
         end
      end
   end

   task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         expect_bit(cur_req, "card_drv_lo", card_drv_lo, !line_en || (mode == 3 && who == 0));
         expect_bit(cur_req, "card_drv_hi", card_drv_hi, line_en && mode == 4 && who == 0);
         expect_bit(cur_req, "host_drv_lo", host_drv_lo, line_en && mode == 3 && who == 1);
         expect_bit(cur_req, "host_drv_hi", host_drv_hi, line_en && mode == 4 && who == 1);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int hi_cnt;
      cyc(3);
      rst_n = 1'b1;
      cyc(4);
      // R1 reset/idle
      cur_req = "R1";
      expect_bit("R1", "all released", host_drv_lo | host_drv_hi | card_drv_lo | card_drv_hi, 1'b0);

      // R3 / R6: host master, exact delay
      cur_req = "R3";
      host_ext = 1'b1;
      cyc(ED + 2);
      expect_bit("R6", "card_drv_lo before delay", card_drv_lo, 1'b0);
      cyc(1);
      expect_bit("R6", "card_drv_lo after delay", card_drv_lo, 1'b1);
      expect_bit("R3", "host side undriven", host_drv_lo, 1'b0);
      cyc(10);
      // R7: release and pulse length
      cur_req = "R7";
      host_ext = 1'b0;
      hi_cnt = 0;
      for (int i = 0; i < 20; i++) begin
         cyc(1);
         if (card_drv_hi) hi_cnt++;
      end
      expect_bit("R7", "pulse length ok", hi_cnt == PU, 1'b1);
      expect_bit("R7", "pull-down released", card_drv_lo, 1'b0);

      // R2: card master
      cur_req = "R2";
      card_ext = 1'b1;
      cyc(ED + 6);
      expect_bit("R2", "host_drv_lo", host_drv_lo, 1'b1);
      expect_bit("R2", "card_drv_lo", card_drv_lo, 1'b0);
      card_ext = 1'b0;
      cyc(20);

      // R4: simultaneous fall
      cur_req = "R4";
      host_ext = 1'b1; card_ext = 1'b1;
      cyc(ED + 6);
      expect_bit("R4", "card_drv_lo", card_drv_lo, 1'b1);
      expect_bit("R4", "host_drv_lo", host_drv_lo, 1'b0);
      card_ext = 1'b0;
      cyc(3);
      // R5: extra slave lows are ignored
      cur_req = "R5";
      card_ext = 1'b1; cyc(2); card_ext = 1'b0; cyc(2); card_ext = 1'b1;
      cyc(3);
      expect_bit("R5", "host_drv_lo", host_drv_lo, 1'b0);
      expect_bit("R5", "card_drv_lo", card_drv_lo, 1'b1);
      // R9: card held low across end of pulse, then release host
      cur_req = "R9";
      host_ext = 1'b0;
      cyc(30);
      expect_bit("R9", "no drive while card low", host_drv_lo | card_drv_lo | host_drv_hi | card_drv_hi, 1'b0);
      card_ext = 1'b0;
      cyc(10);
      host_ext = 1'b1;
      cyc(ED + 6);
      expect_bit("R9", "rearmed session", card_drv_lo, 1'b1);
      host_ext = 1'b0;
      cyc(20);

      // R8: short master low
      cur_req = "R8";
      host_ext = 1'b1; cyc(3); host_ext = 1'b0;
      hi_cnt = 0;
      for (int i = 0; i < 25; i++) begin
         cyc(1);
         if (card_drv_lo || card_drv_hi) hi_cnt++;
      end
      expect_bit("R8", "no slave drive", hi_cnt == 0, 1'b1);

      // R10: enable low aborts
      cur_req = "R10";
      card_ext = 1'b1;
      cyc(ED + 6);
      line_en = 1'b0;
      cyc(1);
      expect_bit("R10", "card_drv_lo", card_drv_lo, 1'b1);
      expect_bit("R10", "host_drv_lo", host_drv_lo, 1'b0);
      expect_bit("R10", "host_drv_hi", host_drv_hi, 1'b0);
      card_ext = 1'b0;
      cyc(5);
      line_en = 1'b1;
      cyc(10);
      expect_bit("R10", "released after enable", card_drv_lo | host_drv_lo, 1'b0);
      host_ext = 1'b1;
      cyc(ED + 6);
      expect_bit("R10", "new session after enable", card_drv_lo, 1'b1);
      host_ext = 1'b0;
      cyc(20);
      finish_run();
   end
endmodule